// File: doc/BRIEF.md
# BIST Frame Launch Controller

This block starts a built-in self-test frame on one of several serial links, on a request from software. Each link has an initiate bit. A 0-to-1 transition of that bit asks for one launch on that link. The block first checks that a device is attached to the link and that the link is out of its low-power states. It then builds a three-DWord frame and streams it out on a shared transmit channel. After that it waits for the link to report whether the frame completed or failed.

A 6-bit mode field and two 32-bit payload words are shared by every link. They are sampled when a launch is granted. When several requests are waiting, only one link transmits at a time, and the lowest-numbered waiting link goes first. A successful launch locks its link. The lock releases only after the link's enable has gone low and then high again. A failed launch sets a fail flag, and software retries by clearing and re-setting the initiate bit.

The transmit channel is valid/ready, with one DWord per beat. While `tx_valid` is high and `tx_ready` is low, the block holds `tx_data`, `tx_last` and `tx_port` unchanged. A beat is taken on each clock edge where both signals are high. The receiver may apply back-pressure for any number of cycles.

Top module: `bist_launch_ctrl`

## Requirements
- R1: A launch on a link is requested only by a 0-to-1 transition of its bit in `start_bit`. Holding the bit high never requests another launch.
- R2: Take a rising edge on a link where `dev_present` and `link_ready` are not both high. That request is dropped and sets that link's `fail_flag` on the next clock. No frame is sent for it.
- R3: Frame beat 0 (the first beat) carries 58h in bits 7:0, zero in bits 15:8, `{bist_mode, 2'b00}` in bits 23:16 and zero in bits 31:24.
- R4: Beat 1 always equals `tx_word1` and beat 2 always equals `tx_word2`, whatever the value of `bist_mode[5]` (far-end transmit).
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data`, `tx_last` and `tx_port` stay stable. `tx_last` is high on beat 2 only.
- R6: One frame is handled at a time, from its first beat until its response. Requests that arrive meanwhile are held pending and served lowest link index first. `tx_port` gives the link of the current frame.
- R7: A `port_done` pulse for the link in flight, after its last beat, sets that link's `pass_flag` and locks the link. Rising edges on a locked link are ignored. The lock and `pass_flag` clear only when `port_enable` for that link goes low and then high.
- R8: A `port_err` pulse for the link in flight sets its `fail_flag`. If `port_err` and `port_done` arrive in the same cycle, `port_err` wins. A new accepted request clears `fail_flag`, so retries are unlimited. A flag is never cleared in any other way.
- R9: After reset, `tx_valid`, `busy`, `pass_flag` and `fail_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_bit | input | NUM_PORTS | Per-link initiate bits; a rising edge requests a launch |
| port_enable | input | NUM_PORTS | Per-link enable; a low-then-high cycle releases the lock |
| dev_present | input | NUM_PORTS | Device attached on the link |
| link_ready | input | NUM_PORTS | Link active, not in a low-power state |
| bist_mode | input | 6 | Shared mode bits, placed in bits 23:18 of beat 0 |
| tx_word1 | input | 32 | Shared payload word, sent as beat 1 |
| tx_word2 | input | 32 | Shared payload word, sent as beat 2 |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit receiver accepts the beat |
| tx_data | output | 32 | Transmit DWord |
| tx_last | output | 1 | Final beat of the frame |
| tx_port | output | $clog2(NUM_PORTS) | Link that the current frame targets |
| port_done | input | NUM_PORTS | Per-link completion pulse |
| port_err | input | NUM_PORTS | Per-link failure pulse |
| pass_flag | output | NUM_PORTS | Per-link success status; high while the link is locked |
| fail_flag | output | NUM_PORTS | Per-link failure status |
| busy | output | 1 | A frame is being sent or awaits its response |

## Verification
The hardest situation to reach is several links waiting at once while a frame is still in flight. The bench gets there by starting one link and holding back its response. While that link is waiting, it raises three other initiate bits on the same clock, then releases the responses one by one and checks the order in which the links are served. The lock release needs the initiate bit to toggle while the lock is held, and then an enable low-high cycle. The bench does both on purpose. Its random loop cycles enable on each locked link before the next launch on that link.

// File: rtl/bist_launch_pkg.sv
package bist_launch_pkg;

  localparam logic [7:0] BIST_FIS_CODE = 8'h58;
  localparam int         FRAME_BEATS   = 3;
  localparam int         MODE_W        = 6;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;

  typedef enum logic [1:0] {
    LK_OPEN = 2'd0,
    LK_HELD = 2'd1,
    LK_OFF  = 2'd2
  } lock_state_e;

  // first DWord: type code, zero, pattern byte (mode over two zero bits), zero
  function automatic logic [31:0] bist_dw0(input logic [MODE_W-1:0] mode);
    return {8'h00, mode, 2'b00, 8'h00, BIST_FIS_CODE};
  endfunction

endpackage

// File: rtl/bist_port_ctl.sv
module bist_port_ctl
  import bist_launch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_bit,
  input  logic port_enable,
  input  logic eligible,
  input  logic grant,
  input  logic done_in,
  input  logic err_in,
  output logic pending,
  output logic pass_flag,
  output logic fail_flag,
  output logic locked
);

  logic        start_q;
  logic        active;
  lock_state_e lk_st;
  logic        rise;
  logic        accept;

  assign rise   = start_bit & ~start_q;
  assign accept = rise & (lk_st == LK_OPEN) & ~pending & ~active;
  assign locked = (lk_st != LK_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      active    <= 1'b0;
      pending   <= 1'b0;
      pass_flag <= 1'b0;
      fail_flag <= 1'b0;
      lk_st     <= LK_OPEN;
    end else begin
      start_q <= start_bit;
      if (accept) begin
        if (eligible) begin
          pending   <= 1'b1;
          fail_flag <= 1'b0;
        end else begin
          fail_flag <= 1'b1;
        end
      end
      if (grant) begin
        pending <= 1'b0;
        active  <= 1'b1;
      end
      if (active && err_in) begin
        active    <= 1'b0;
        fail_flag <= 1'b1;
      end else if (active && done_in) begin
        active    <= 1'b0;
        pass_flag <= 1'b1;
        lk_st     <= LK_HELD;
      end
      case (lk_st)
        LK_HELD: if (!port_enable) lk_st <= LK_OFF;
        LK_OFF: if (port_enable) begin
          lk_st     <= LK_OPEN;
          pass_flag <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bist_prio_arb.sv
module bist_prio_arb #(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS-1:0] req,
  input  logic                 enable,
  output logic [NUM_PORTS-1:0] gnt,
  output logic [PORT_W-1:0]    gnt_idx,
  output logic                 gnt_any
);

  logic found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (req[i] && !found) begin
        gnt[i]  = enable;
        gnt_idx = PORT_W'(i);
        found   = 1'b1;
      end
    end
    gnt_any = found & enable;
  end

endmodule

// File: rtl/bist_fis_tx.sv
module bist_fis_tx
  import bist_launch_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PORT_W-1:0] start_idx,
  input  logic [MODE_W-1:0] mode,
  input  logic [31:0]       word1,
  input  logic [31:0]       word2,
  input  logic              result,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [31:0]       tx_data,
  output logic              tx_last,
  output logic [PORT_W-1:0] tx_port,
  output logic              waiting,
  output logic              idle
);

  localparam int BEAT_W = $clog2(FRAME_BEATS);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(FRAME_BEATS - 1);

  tx_state_e                         st;
  logic [BEAT_W-1:0]                 beat;
  logic [FRAME_BEATS-1:0][31:0]      frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TX_IDLE;
      beat    <= '0;
      frame   <= '0;
      tx_port <= '0;
    end else begin
      case (st)
        TX_IDLE: if (start) begin
          frame[0] <= bist_dw0(mode);
          frame[1] <= word1;
          frame[2] <= word2;
          tx_port  <= start_idx;
          beat     <= '0;
          st       <= TX_SEND;
        end
        TX_SEND: if (tx_ready) begin
          if (beat == LAST_BEAT) st <= TX_WAIT;
          else                   beat <= beat + 1'b1;
        end
        TX_WAIT: if (result) st <= TX_IDLE;
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign tx_valid = (st == TX_SEND);
  assign tx_data  = frame[beat];
  assign tx_last  = (beat == LAST_BEAT);
  assign waiting  = (st == TX_WAIT);
  assign idle     = (st == TX_IDLE);

endmodule

// File: rtl/bist_launch_ctrl.sv
module bist_launch_ctrl
  import bist_launch_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] start_bit,
  input  logic [NUM_PORTS-1:0] port_enable,
  input  logic [NUM_PORTS-1:0] dev_present,
  input  logic [NUM_PORTS-1:0] link_ready,
  input  logic [MODE_W-1:0]    bist_mode,
  input  logic [31:0]          tx_word1,
  input  logic [31:0]          tx_word2,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [31:0]          tx_data,
  output logic                 tx_last,
  output logic [PORT_W-1:0]    tx_port,
  input  logic [NUM_PORTS-1:0] port_done,
  input  logic [NUM_PORTS-1:0] port_err,
  output logic [NUM_PORTS-1:0] pass_flag,
  output logic [NUM_PORTS-1:0] fail_flag,
  output logic                 busy
);

  logic [NUM_PORTS-1:0] pending;
  logic [NUM_PORTS-1:0] locked;
  logic [NUM_PORTS-1:0] gnt;
  logic [NUM_PORTS-1:0] sel_onehot;
  logic [NUM_PORTS-1:0] done_q;
  logic [NUM_PORTS-1:0] err_q;
  logic [PORT_W-1:0]    gnt_idx;
  logic                 gnt_any;
  logic                 waiting;
  logic                 idle;
  logic                 result;

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) sel_onehot[i] = (tx_port == PORT_W'(i));
  end

  assign done_q = port_done & sel_onehot & {NUM_PORTS{waiting}};
  assign err_q  = port_err  & sel_onehot & {NUM_PORTS{waiting}};
  assign result = |(done_q | err_q);
  assign busy   = ~idle;

  bist_prio_arb #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .req     (pending),
    .enable  (idle),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  bist_fis_tx #(.NUM_PORTS(NUM_PORTS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (gnt_any),
    .start_idx (gnt_idx),
    .mode      (bist_mode),
    .word1     (tx_word1),
    .word2     (tx_word2),
    .result    (result),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_port   (tx_port),
    .waiting   (waiting),
    .idle      (idle)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    bist_port_ctl u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_bit   (start_bit[p]),
      .port_enable (port_enable[p]),
      .eligible    (dev_present[p] & link_ready[p]),
      .grant       (gnt[p]),
      .done_in     (done_q[p]),
      .err_in      (err_q[p]),
      .pending     (pending[p]),
      .pass_flag   (pass_flag[p]),
      .fail_flag   (fail_flag[p]),
      .locked      (locked[p])
    );
  end

endmodule

// File: rtl/bist_launch_chk.sv
module bist_launch_chk
  import bist_launch_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] start_bit,
  input logic [NUM_PORTS-1:0] port_enable,
  input logic [MODE_W-1:0]    bist_mode,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic [31:0]          tx_data,
  input logic                 tx_last,
  input logic [PORT_W-1:0]    tx_port,
  input logic [NUM_PORTS-1:0] pass_flag,
  input logic [NUM_PORTS-1:0] fail_flag,
  input logic                 busy
);

  logic [1:0]           seen_beats;
  logic [NUM_PORTS-1:0] start_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_beats <= '0;
      start_prev <= '0;
    end else begin
      start_prev <= start_bit;
      if (tx_valid && tx_ready) seen_beats <= (seen_beats == 2'd2) ? 2'd0 : seen_beats + 2'd1;
    end
  end

  a_r5_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_port));

  a_r5_last_on_third: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_last == (seen_beats == 2'd2)));

  a_r3_header_layout: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && seen_beats == 2'd0 |->
      tx_data[7:0] == 8'h58 && tx_data[15:8] == 8'h00 && tx_data[17:16] == 2'b00 && tx_data[31:24] == 8'h00);

  a_r6_port_steady: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(tx_port));

  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    a_r7_pass_kept_while_off: assert property (@(posedge clk) disable iff (!rst_n)
      pass_flag[p] && !port_enable[p] |=> pass_flag[p]);

    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fail_flag[p] && !(start_bit[p] && !start_prev[p]) |=> fail_flag[p]);

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pass_flag[p], fail_flag[p]}));
  end

endmodule

bind bist_launch_ctrl bist_launch_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (.*);

// File: tb/tb_bist_launch_ctrl.sv
module tb_bist_launch_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] start_bit = '0, port_enable = '1, dev_present = '1, link_ready = '1;
  logic [NP-1:0] port_done = '0, port_err = '0;
  logic [5:0]    bist_mode = '0;
  logic [31:0]   tx_word1 = '0, tx_word2 = '0;
  logic          tx_ready = 1'b0;
  logic          tx_valid, tx_last, busy;
  logic [31:0]   tx_data;
  logic [1:0]    tx_port;
  logic [NP-1:0] pass_flag, fail_flag;

  int checks = 0, errors = 0;
  bit finished = 0;
  int ncap = 0;
  logic [31:0] cap_d [0:1023];
  logic [1:0]  cap_p [0:1023];
  logic        cap_l [0:1023];
  logic [NP-1:0] exp_pass = '0, exp_fail = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bist_launch_ctrl #(.NUM_PORTS(NP)) dut (.*);

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && ncap < 1024) begin
      cap_d[ncap] = tx_data;
      cap_p[ncap] = tx_port;
      cap_l[ncap] = tx_last;
      ncap++;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    forever begin
      @(posedge clk);
      #1 tx_ready = ($urandom % 4) != 0;
    end
  end

  function automatic logic [31:0] exp_dw0(input logic [5:0] m);
    return {8'h00, m, 2'b00, 8'h00, 8'h58};
  endfunction

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_beats(input int n);
    int guard = 0;
    while (ncap < n && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic set_start(input int p, input logic v);
    @(negedge clk);
    start_bit[p] = v;
  endtask

  task automatic respond(input int p, input bit bad);
    @(negedge clk);
    if (bad) port_err[p] = 1'b1; else port_done[p] = 1'b1;
    @(negedge clk);
    port_err[p]  = 1'b0;
    port_done[p] = 1'b0;
    tick(1);
  endtask

  task automatic check_frame(input int base, input int p, input string req);
    chk(ncap >= base + 3, req, $sformatf("beats got %0d expected %0d", ncap - base, 3));
    if (ncap >= base + 3) begin
      chk(cap_d[base] == exp_dw0(bist_mode), "R3",
          $sformatf("dw0 got %h expected %h", cap_d[base], exp_dw0(bist_mode)));
      chk(cap_d[base+1] == tx_word1 && cap_d[base+2] == tx_word2, "R4",
          $sformatf("dw1/dw2 got %h/%h expected %h/%h", cap_d[base+1], cap_d[base+2], tx_word1, tx_word2));
      chk(!cap_l[base] && !cap_l[base+1] && cap_l[base+2], "R5",
          $sformatf("last marks got %b%b%b expected 001", cap_l[base], cap_l[base+1], cap_l[base+2]));
      chk(cap_p[base] == 2'(p), req, $sformatf("port got %0d expected %0d", cap_p[base], p));
    end
  endtask

  task automatic check_flags(input string req);
    chk(pass_flag == exp_pass && fail_flag == exp_fail, req,
        $sformatf("pass/fail got %b/%b expected %b/%b", pass_flag, fail_flag, exp_pass, exp_fail));
  endtask

  task automatic cycle_enable(input int p);
    @(negedge clk); port_enable[p] = 1'b0;
    tick(2);
    chk(pass_flag[p] == exp_pass[p], "R7", $sformatf("pass during disable got %b expected %b", pass_flag[p], exp_pass[p]));
    port_enable[p] = 1'b1;
    tick(2);
    exp_pass[p] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R9 reset state
    chk(!tx_valid && !busy && pass_flag == '0 && fail_flag == '0, "R9",
        $sformatf("valid/busy/pass/fail got %b/%b/%b/%b expected 0/0/0/0", tx_valid, busy, pass_flag, fail_flag));

    // R4 with far-end transmit bit clear, R8 error response
    bist_mode = 6'b011010; tx_word1 = 32'hCAFE_0001; tx_word2 = 32'h1234_5678;
    base = ncap;
    set_start(2, 1'b1);
    wait_beats(base + 3);
    check_frame(base, 2, "R6");
    respond(2, 1'b1);
    exp_fail[2] = 1'b1;
    check_flags("R8");
    // R1 level held high: no new frame
    base = ncap;
    tick(20);
    chk(ncap == base, "R1", $sformatf("beats while held got %0d expected 0", ncap - base));
    // R8 retry clears fail then succeeds
    set_start(2, 1'b0);
    set_start(2, 1'b1);
    wait_beats(base + 3);
    exp_fail[2] = 1'b0;
    check_flags("R8");
    check_frame(base, 2, "R8");
    respond(2, 1'b0);
    exp_pass[2] = 1'b1;
    check_flags("R7");
    // R7 locked port ignores a new edge
    set_start(2, 1'b0);
    set_start(2, 1'b1);
    base = ncap;
    tick(20);
    chk(ncap == base, "R7", $sformatf("beats while locked got %0d expected 0", ncap - base));
    check_flags("R7");
    cycle_enable(2);
    check_flags("R7");
    set_start(2, 1'b0);
    set_start(2, 1'b1);
    wait_beats(base + 3);
    check_frame(base, 2, "R7");
    respond(2, 1'b0);
    exp_pass[2] = 1'b1;
    set_start(2, 1'b0);
    cycle_enable(2);

    // R2 link in low-power state
    link_ready[0] = 1'b0;
    base = ncap;
    set_start(0, 1'b1);
    tick(1);
    exp_fail[0] = 1'b1;
    check_flags("R2");
    tick(10);
    chk(ncap == base && !busy, "R2", $sformatf("beats got %0d expected 0", ncap - base));
    set_start(0, 1'b0);
    link_ready[0] = 1'b1;
    // R2 device absent
    dev_present[3] = 1'b0;
    set_start(3, 1'b1);
    tick(1);
    exp_fail[3] = 1'b1;
    check_flags("R2");
    set_start(3, 1'b0);
    dev_present[3] = 1'b1;

    // R6 pending requests served lowest index first
    bist_mode = 6'b100101; tx_word1 = 32'hA5A5_0F0F; tx_word2 = 32'h0000_FFFF;
    base = ncap;
    set_start(1, 1'b1);
    wait_beats(base + 3);
    check_frame(base, 1, "R6");
    @(negedge clk);
    start_bit[3] = 1'b1; start_bit[2] = 1'b1; start_bit[0] = 1'b1;
    tick(5);
    chk(ncap == base + 3 && busy, "R6", $sformatf("beats before response got %0d expected 3", ncap - base));
    respond(1, 1'b0);
    exp_pass[1] = 1'b1;
    exp_fail[0] = 1'b0; exp_fail[3] = 1'b0;
    foreach (exp_pass[k]) ;
    for (int k = 0; k < 3; k++) begin
      int want;
      want = (k == 0) ? 0 : (k == 1) ? 2 : 3;
      wait_beats(base + 6 + 3*k);
      check_frame(base + 3 + 3*k, want, "R6");
      respond(want, 1'b0);
      exp_pass[want] = 1'b1;
    end
    check_flags("R7");
    start_bit = '0;
    for (int p = 0; p < NP; p++) cycle_enable(p);
    check_flags("R7");

    // random launches
    for (int it = 0; it < 40; it++) begin
      int p;
      bit ok, bad;
      p = $urandom % NP;
      ok = ($urandom % 4) != 0;
      bad = ($urandom % 3) == 0;
      bist_mode = 6'($urandom); tx_word1 = $urandom; tx_word2 = $urandom;
      if (!ok) begin
        if ($urandom % 2) dev_present[p] = 1'b0; else link_ready[p] = 1'b0;
      end
      base = ncap;
      set_start(p, 1'b1);
      if (ok) begin
        wait_beats(base + 3);
        check_frame(base, p, "R6");
        respond(p, bad);
        if (bad) exp_fail[p] = 1'b1; else begin exp_pass[p] = 1'b1; exp_fail[p] = 1'b0; end
        check_flags(bad ? "R8" : "R7");
      end else begin
        tick(6);
        exp_fail[p] = 1'b1;
        chk(ncap == base, "R2", $sformatf("beats got %0d expected 0", ncap - base));
        check_flags("R2");
      end
      set_start(p, 1'b0);
      dev_present[p] = 1'b1; link_ready[p] = 1'b1;
      if (exp_pass[p]) cycle_enable(p);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule